// File: doc/BRIEF.md
# Misaligned Request Merging Buffer

This block sits between a set of load-store units and a two-bank interleaved cache whose lines are 16 bytes wide. In every clock cycle each of the sixteen units may present one narrow access of 1, 2, 4 or 8 bytes at any byte address. The buffer folds these into at most one line-aligned request per bank. Line addresses with bit 4 clear go to the even bank and those with it set go to the odd bank. It behaves as a single-way staging buffer, not as a cache: nothing is kept from one cycle to the next beyond the registered request.

An access that runs past a line boundary is split into two pieces, one in each bank, and is granted only when both pieces are issued together. In each bank the lowest-numbered valid input with a piece there fixes the line for the cycle. Later inputs on that line are merged when they do not mix a load and a store on the same byte. Merged store bytes are placed at their line positions, with the higher-numbered input winning a shared byte. Bank requests and per-input grants appear one cycle after the inputs. While a bank request is held, read data from the banks is steered back to each granted input, and a split access is reassembled from both banks.

Top module: `misalign_merge_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released with no valid inputs, req_gnt, bk_vld, bk_mask, bk_wstrb and bk_wdata are all zero.
- R2: A valid input with size code s (0, 1, 2, 3 meaning 1, 2, 4, 8 bytes) at address A that does not cross a line is issued on the bank selected by A[4], with bk_line equal to A[15:4] and mask bits A[3:0] up to A[3:0]+bytes-1 set. The request appears one clock edge after the input.
- R3: An input whose last byte lies in the next 16-byte line drives both banks, low bytes in line A[15:4] and the rest from bit 0 of line A[15:4]+1. It is granted only when both pieces are accepted. A refused split input places nothing on either bank.
- R4: In each bank the lowest-numbered valid input with a piece in that bank sets bk_line. Any input with a piece in that bank on a different line is not granted.
- R5: bk_mask of a bank is the OR of the byte positions of every granted piece in that bank, and bk_vld is set exactly when some granted piece falls in that bank.
- R6: When granted stores write the same byte, bk_wdata holds the data of the highest-numbered of them. Store data byte k of an input lands at line position (A+k) mod 16.
- R7: An input whose load bytes overlap already accepted store bytes of a lower-numbered input in the same bank, or whose store bytes overlap already accepted load bytes, is not granted.
- R8: For a granted load, byte k of ld_data equals byte (A+k) mod 16 of bk_rdata of bank bit 4 of A+k, read in the same cycle as the grant.
- R9: A grant is only given to an input that was valid, and the lowest-numbered valid input is always granted.
- R10: bk_wstrb marks exactly the bytes written by granted stores and is always contained in bk_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | NUM_REQ | Per-input request valid |
| req_addr | input | NUM_REQ x ADDR_W | Byte address per input |
| req_size | input | NUM_REQ x 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_st | input | NUM_REQ | 1 = store, 0 = load |
| req_wdata | input | NUM_REQ x DATA_W | Store data, byte 0 in bits 7:0 |
| req_gnt | output | NUM_REQ | Registered grant per input |
| ld_data | output | NUM_REQ x DATA_W | Steered load data per input |
| bk_vld | output | 2 | Request valid, index 0 even bank, 1 odd bank |
| bk_line | output | 2 x (ADDR_W-4) | Line address per bank |
| bk_mask | output | 2 x 16 | Bytes touched per bank |
| bk_wstrb | output | 2 x 16 | Bytes written per bank |
| bk_wdata | output | 2 x 128 | Merged store data per bank |
| bk_rdata | input | 2 x 128 | Read data returned by each bank |

## Verification
Directed cases separate the single in-line access, the boundary-crossing access that is accepted, and the crossing access refused because its second bank is owned by another line. They also cover a same-bank different-line stall, several adjacent stores merging, an overlapping store pair whose winner shows in the data bytes, and load-store collisions in both orders. A long random run with addresses packed into a few lines then mixes all of these cases against a byte-level model. Bank read data is changed in every cycle, so wrong load steering or wrong reassembly of split loads shows up as data errors.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
    localparam int LINE_BYTES = 16;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int SPAN_B     = 2 * LINE_BYTES;
    localparam int SPAN_W     = 2 * LINE_W;
    localparam int NUM_BANKS  = 2;
    localparam int SZ_W       = 2;
endpackage

// File: rtl/mrb_piece_dec.sv
module mrb_piece_dec
    import mrb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0]                          addr,
    input  logic [SZ_W-1:0]                            size,
    input  logic [DATA_W-1:0]                          wdata,
    output logic [NUM_BANKS-1:0]                       has,
    output logic [NUM_BANKS-1:0][ADDR_W-OFF_W-1:0]     line,
    output logic [NUM_BANKS-1:0][LINE_BYTES-1:0]       mask,
    output logic [NUM_BANKS-1:0][LINE_W-1:0]           data
);
    localparam int LA_W = ADDR_W - OFF_W;
    localparam int DB   = DATA_W / 8;

    logic [SPAN_B-1:0] base;
    logic [SPAN_B-1:0] span_m;
    logic [SPAN_W-1:0] span_d;
    logic [LA_W-1:0]   lo_line;
    logic [LA_W-1:0]   hi_line;
    logic              crosses;

    always_comb begin
        base = '0;
        for (int k = 0; k < DB; k++) begin
            if (k < (32'd1 << size)) base[k] = 1'b1;
        end
    end

    assign span_m  = base << addr[OFF_W-1:0];
    assign span_d  = SPAN_W'(wdata) << {addr[OFF_W-1:0], 3'b000};
    assign crosses = |span_m[SPAN_B-1:LINE_BYTES];
    assign lo_line = addr[ADDR_W-1:OFF_W];
    assign hi_line = lo_line + LA_W'(1);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            if (lo_line[0] == 1'(b)) begin
                has[b]  = 1'b1;
                line[b] = lo_line;
                mask[b] = span_m[LINE_BYTES-1:0];
                data[b] = span_d[LINE_W-1:0];
            end else begin
                has[b]  = crosses;
                line[b] = hi_line;
                mask[b] = span_m[SPAN_B-1:LINE_BYTES];
                data[b] = span_d[SPAN_W-1:LINE_W];
            end
        end
    end
endmodule

// File: rtl/mrb_ld_steer.sv
module mrb_ld_steer
    import mrb_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [OFF_W-1:0]                 off,
    input  logic                             lo_bank,
    input  logic [NUM_BANKS-1:0][LINE_W-1:0] rdata,
    output logic [DATA_W-1:0]                ld
);
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] shifted;

    assign span    = {rdata[~lo_bank], rdata[lo_bank]};
    assign shifted = span >> {off, 3'b000};
    assign ld      = shifted[DATA_W-1:0];
endmodule

// File: rtl/misalign_merge_buf.sv
module misalign_merge_buf
    import mrb_pkg::*;
#(
    parameter int NUM_REQ = 16,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_REQ-1:0]                     req_vld,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]         req_addr,
    input  logic [NUM_REQ-1:0][SZ_W-1:0]           req_size,
    input  logic [NUM_REQ-1:0]                     req_st,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]         req_wdata,
    output logic [NUM_REQ-1:0]                     req_gnt,
    output logic [NUM_REQ-1:0][DATA_W-1:0]         ld_data,
    output logic [NUM_BANKS-1:0]                   bk_vld,
    output logic [NUM_BANKS-1:0][ADDR_W-OFF_W-1:0] bk_line,
    output logic [NUM_BANKS-1:0][LINE_BYTES-1:0]   bk_mask,
    output logic [NUM_BANKS-1:0][LINE_BYTES-1:0]   bk_wstrb,
    output logic [NUM_BANKS-1:0][LINE_W-1:0]       bk_wdata,
    input  logic [NUM_BANKS-1:0][LINE_W-1:0]       bk_rdata
);
    localparam int LA_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [NUM_BANKS-1:0]                 vld;
        logic [NUM_BANKS-1:0][LA_W-1:0]       line;
        logic [NUM_BANKS-1:0][LINE_BYTES-1:0] mask;
        logic [NUM_BANKS-1:0][LINE_BYTES-1:0] wstrb;
        logic [NUM_BANKS-1:0][LINE_W-1:0]     wdata;
        logic [NUM_REQ-1:0]                   gnt;
        logic [NUM_REQ-1:0][OFF_W-1:0]        off;
        logic [NUM_REQ-1:0]                   lob;
    } mrb_state_t;

    mrb_state_t s_d, s_q;

    logic [NUM_REQ-1:0][NUM_BANKS-1:0]                 p_has;
    logic [NUM_REQ-1:0][NUM_BANKS-1:0][LA_W-1:0]       p_line;
    logic [NUM_REQ-1:0][NUM_BANKS-1:0][LINE_BYTES-1:0] p_mask;
    logic [NUM_REQ-1:0][NUM_BANKS-1:0][LINE_W-1:0]     p_data;

    logic [NUM_BANKS-1:0]                 lead_found;
    logic [NUM_BANKS-1:0][LINE_BYTES-1:0] acc_ld;
    logic [NUM_BANKS-1:0][LINE_BYTES-1:0] acc_st;
    logic                                 fits;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        mrb_piece_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
            .addr  (req_addr[i]),
            .size  (req_size[i]),
            .wdata (req_wdata[i]),
            .has   (p_has[i]),
            .line  (p_line[i]),
            .mask  (p_mask[i]),
            .data  (p_data[i])
        );

        mrb_ld_steer #(.DATA_W(DATA_W)) u_steer (
            .off     (s_q.off[i]),
            .lo_bank (s_q.lob[i]),
            .rdata   (bk_rdata),
            .ld      (ld_data[i])
        );
    end

    always_comb begin
        s_d        = '0;
        lead_found = '0;
        acc_ld     = '0;
        acc_st     = '0;
        fits       = 1'b0;

        // each bank follows the line of its lowest-numbered valid piece
        for (int i = 0; i < NUM_REQ; i++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (req_vld[i] && p_has[i][b] && !lead_found[b]) begin
                    lead_found[b] = 1'b1;
                    s_d.line[b]   = p_line[i][b];
                end
            end
        end

        // accept in ascending order; both pieces of a split must fit
        for (int i = 0; i < NUM_REQ; i++) begin
            fits = req_vld[i];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (p_has[i][b]) begin
                    if (p_line[i][b] != s_d.line[b]) fits = 1'b0;
                    if (req_st[i]) begin
                        if (|(p_mask[i][b] & acc_ld[b])) fits = 1'b0;
                    end else begin
                        if (|(p_mask[i][b] & acc_st[b])) fits = 1'b0;
                    end
                end
            end
            if (fits) begin
                s_d.gnt[i] = 1'b1;
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (p_has[i][b]) begin
                        s_d.mask[b] = s_d.mask[b] | p_mask[i][b];
                        if (req_st[i]) begin
                            acc_st[b] = acc_st[b] | p_mask[i][b];
                            for (int k = 0; k < LINE_BYTES; k++) begin
                                if (p_mask[i][b][k])
                                    s_d.wdata[b][k*8 +: 8] = p_data[i][b][k*8 +: 8];
                            end
                        end else begin
                            acc_ld[b] = acc_ld[b] | p_mask[i][b];
                        end
                    end
                end
            end
            s_d.off[i] = req_addr[i][OFF_W-1:0];
            s_d.lob[i] = req_addr[i][OFF_W];
        end

        s_d.wstrb = acc_st;
        for (int b = 0; b < NUM_BANKS; b++) begin
            s_d.vld[b] = |s_d.mask[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_gnt  = s_q.gnt;
    assign bk_vld   = s_q.vld;
    assign bk_line  = s_q.line;
    assign bk_mask  = s_q.mask;
    assign bk_wstrb = s_q.wstrb;
    assign bk_wdata = s_q.wdata;
endmodule

// File: rtl/mrb_chk.sv
module mrb_chk
    import mrb_pkg::*;
#(
    parameter int NUM_REQ = 16
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_REQ-1:0]                   req_vld,
    input logic [NUM_REQ-1:0]                   req_gnt,
    input logic [NUM_BANKS-1:0]                 bk_vld,
    input logic [NUM_BANKS-1:0][LINE_BYTES-1:0] bk_mask,
    input logic [NUM_BANKS-1:0][LINE_BYTES-1:0] bk_wstrb
);
    // R10
    wstrb_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk_wstrb[0] & ~bk_mask[0]) == '0) && ((bk_wstrb[1] & ~bk_mask[1]) == '0));

    // R9
    gnt_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((req_gnt & ~$past(req_vld)) == '0));

    // R9
    lowest_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(req_vld) != '0)) |-> (req_gnt != '0));

    // R5
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_gnt == '0) |-> (bk_vld == '0));
endmodule

bind misalign_merge_buf mrb_chk #(.NUM_REQ(NUM_REQ)) u_chk (.*);

// File: tb/sim_misalign_merge_buf.sv
module sim_misalign_merge_buf;
    localparam int  N      = 16;
    localparam int  AW     = 16;
    localparam int  DW     = 64;
    localparam int  LW     = 128;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]          req_vld = '0;
    logic [N-1:0][AW-1:0]  req_addr = '0;
    logic [N-1:0][1:0]     req_size = '0;
    logic [N-1:0]          req_st = '0;
    logic [N-1:0][DW-1:0]  req_wdata = '0;
    logic [N-1:0]          req_gnt;
    logic [N-1:0][DW-1:0]  ld_data;
    logic [1:0]            bk_vld;
    logic [1:0][AW-5:0]    bk_line;
    logic [1:0][15:0]      bk_mask;
    logic [1:0][15:0]      bk_wstrb;
    logic [1:0][LW-1:0]    bk_wdata;
    logic [1:0][LW-1:0]    bk_rdata = '0;

    logic [N-1:0]       e_gnt;
    logic [1:0]         e_vld;
    logic [1:0][AW-5:0] e_line;
    logic [1:0][15:0]   e_mask, e_wstrb;
    logic [1:0][LW-1:0] e_wd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    misalign_merge_buf #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_size(req_size), .req_st(req_st), .req_wdata(req_wdata),
        .req_gnt(req_gnt), .ld_data(ld_data), .bk_vld(bk_vld), .bk_line(bk_line),
        .bk_mask(bk_mask), .bk_wstrb(bk_wstrb), .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    task automatic chk(input bit good, input string tag, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // byte-level reference: every accessed byte address decides line and bank
    task automatic model();
        logic [1:0] fnd;
        logic [1:0][15:0] ldm, stm;
        logic ok;
        logic [AW-1:0] a;
        logic [AW-5:0] ln;
        int bk, nb;
        fnd = '0; ldm = '0; stm = '0;
        e_gnt = '0; e_mask = '0; e_wd = '0; e_line = '0;
        for (int i = 0; i < N; i++) begin
            if (req_vld[i]) begin
                nb = 1 << req_size[i];
                for (int k = 0; k < nb; k++) begin
                    a = req_addr[i] + AW'(k);
                    ln = a[AW-1:4];
                    bk = int'(ln[0]);
                    if (!fnd[bk]) begin
                        fnd[bk] = 1'b1;
                        e_line[bk] = ln;
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            ok = req_vld[i];
            nb = 1 << req_size[i];
            for (int k = 0; k < nb; k++) begin
                a = req_addr[i] + AW'(k);
                ln = a[AW-1:4];
                bk = int'(ln[0]);
                if (ln != e_line[bk]) ok = 1'b0;
                if (req_st[i] && ldm[bk][a[3:0]]) ok = 1'b0;
                if (!req_st[i] && stm[bk][a[3:0]]) ok = 1'b0;
            end
            if (ok) begin
                e_gnt[i] = 1'b1;
                for (int k = 0; k < nb; k++) begin
                    a = req_addr[i] + AW'(k);
                    bk = int'(a[4]);
                    e_mask[bk][a[3:0]] = 1'b1;
                    if (req_st[i]) begin
                        stm[bk][a[3:0]] = 1'b1;
                        e_wd[bk][int'(a[3:0])*8 +: 8] = req_wdata[i][k*8 +: 8];
                    end else begin
                        ldm[bk][a[3:0]] = 1'b1;
                    end
                end
            end
        end
        e_wstrb = stm;
        e_vld[0] = |e_mask[0];
        e_vld[1] = |e_mask[1];
    endtask

    task automatic check_ld(input string tag);
        logic [DW-1:0] exp, msk;
        logic [AW-1:0] a;
        int nb;
        for (int i = 0; i < N; i++) begin
            if (e_gnt[i] && !req_st[i]) begin
                nb = 1 << req_size[i];
                exp = '0; msk = '0;
                for (int k = 0; k < nb; k++) begin
                    a = req_addr[i] + AW'(k);
                    exp[k*8 +: 8] = bk_rdata[a[4]][int'(a[3:0])*8 +: 8];
                    msk[k*8 +: 8] = 8'hFF;
                end
                chk((ld_data[i] & msk) == exp, tag, $sformatf("R8 ld_data[%0d]", i),
                    LW'(ld_data[i] & msk), LW'(exp));
            end
        end
    endtask

    task automatic check_all(input string tag);
        logic [LW-1:0] wm;
        int low;
        chk(req_gnt == e_gnt, tag, "R9 req_gnt", LW'(req_gnt), LW'(e_gnt));
        low = -1;
        for (int i = N - 1; i >= 0; i--) if (req_vld[i]) low = i;
        if (low >= 0)
            chk(req_gnt[low], tag, "R9 lowest valid granted", LW'(req_gnt), LW'(1) << low);
        chk(bk_vld == e_vld, tag, "R5 bk_vld", LW'(bk_vld), LW'(e_vld));
        for (int b = 0; b < 2; b++) begin
            chk(bk_mask[b] == e_mask[b], tag, "R5 bk_mask", LW'(bk_mask[b]), LW'(e_mask[b]));
            chk(bk_wstrb[b] == e_wstrb[b], tag, "R10 bk_wstrb", LW'(bk_wstrb[b]), LW'(e_wstrb[b]));
            if (e_vld[b])
                chk(bk_line[b] == e_line[b], tag, "R4 bk_line", LW'(bk_line[b]), LW'(e_line[b]));
            wm = '0;
            for (int k = 0; k < 16; k++) if (e_wstrb[b][k]) wm[k*8 +: 8] = 8'hFF;
            chk((bk_wdata[b] & wm) == e_wd[b], tag, "R6 bk_wdata", bk_wdata[b] & wm, e_wd[b]);
        end
    endtask

    task automatic run_cycle(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        bk_rdata = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        #1;
        check_ld(tag);
    endtask

    task automatic clear_in();
        req_vld = '0; req_addr = '0; req_size = '0; req_st = '0; req_wdata = '0;
    endtask

    task automatic put(input int i, input logic [AW-1:0] a, input int sz,
                       input bit st, input logic [DW-1:0] d);
        req_vld[i] = 1'b1; req_addr[i] = a; req_size[i] = 2'(sz);
        req_st[i] = st; req_wdata[i] = d;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_gnt == '0 && bk_vld == '0, "R1", "reset gnt/vld", LW'({bk_vld, req_gnt}), '0);
        chk(bk_mask == '0 && bk_wstrb == '0, "R1", "reset masks", LW'({bk_mask, bk_wstrb}), '0);
        chk(bk_wdata == '0, "R1", "reset wdata", bk_wdata[0] | bk_wdata[1], '0);
        rst_n = 1'b1;
        clear_in();
        run_cycle("R1 idle after reset");

        // R2 single in-line store
        clear_in();
        put(3, 16'h0124, 2, 1'b1, 64'h0000_0000_AABB_CCDD);
        run_cycle("R2 single store");
        chk(bk_vld == 2'b01 && bk_mask[0] == 16'h00F0, "R2", "bank/mask",
            LW'({bk_vld, bk_mask[0]}), LW'({2'b01, 16'h00F0}));
        chk(bk_line[0] == 12'h012 && bk_wdata[0][63:32] == 32'hAABBCCDD, "R2", "line/data",
            LW'({bk_line[0], bk_wdata[0][63:32]}), LW'({12'h012, 32'hAABBCCDD}));

        // R3 accepted split load
        clear_in();
        put(0, 16'h001C, 3, 1'b0, '0);
        run_cycle("R3 split load");
        chk(bk_vld == 2'b11 && bk_mask[1] == 16'hF000 && bk_mask[0] == 16'h000F, "R3", "split masks",
            LW'({bk_vld, bk_mask[1], bk_mask[0]}), LW'({2'b11, 16'hF000, 16'h000F}));

        // R3 refused split: odd bank owned by another line
        clear_in();
        put(0, 16'h0030, 1, 1'b1, 64'h1234);
        put(1, 16'h005C, 3, 1'b0, '0);
        run_cycle("R3 split refused");
        chk(req_gnt == 16'h0001 && bk_vld == 2'b10, "R3", "refused split",
            LW'({bk_vld, req_gnt}), LW'({2'b10, 16'h0001}));

        // R4 same bank, different line stalls
        clear_in();
        put(0, 16'h0200, 2, 1'b0, '0);
        put(1, 16'h0220, 2, 1'b0, '0);
        put(2, 16'h0208, 2, 1'b0, '0);
        run_cycle("R4 line stall");
        chk(req_gnt == 16'h0005, "R4", "stall grant", LW'(req_gnt), LW'(16'h0005));

        // R5 adjacent stores merge
        clear_in();
        for (int i = 0; i < 4; i++) put(i, 16'h0300 + AW'(2 * i), 1, 1'b1, DW'(16'h1111 * (i + 1)));
        put(4, 16'h0310, 0, 1'b0, '0);
        run_cycle("R5 merge");
        chk(req_gnt == 16'h001F && bk_mask[0] == 16'h00FF, "R5", "merged",
            LW'({req_gnt, bk_mask[0]}), LW'({16'h001F, 16'h00FF}));

        // R6 overlapping stores, higher input wins
        clear_in();
        put(2, 16'h0400, 2, 1'b1, 64'h1122_3344);
        put(5, 16'h0401, 1, 1'b1, 64'hBEEF);
        run_cycle("R6 overlap");
        chk(bk_wdata[0][31:0] == 32'h11BEEF44, "R6", "winner bytes",
            LW'(bk_wdata[0][31:0]), LW'(32'h11BEEF44));

        // R7 load then store on same byte
        clear_in();
        put(0, 16'h0500, 2, 1'b0, '0);
        put(1, 16'h0502, 0, 1'b1, 64'h77);
        put(2, 16'h0508, 0, 1'b1, 64'h66);
        run_cycle("R7 ld-st");
        chk(req_gnt == 16'h0005, "R7", "ld then st", LW'(req_gnt), LW'(16'h0005));

        // R7 store then load on same byte
        clear_in();
        put(0, 16'h0600, 1, 1'b1, 64'h5A5A);
        put(1, 16'h0601, 0, 1'b0, '0);
        run_cycle("R7 st-ld");
        chk(req_gnt == 16'h0001 && bk_wstrb[0] == 16'h0003, "R7", "st then ld",
            LW'({req_gnt, bk_wstrb[0]}), LW'({16'h0001, 16'h0003}));

        // mixed random traffic packed into few lines
        for (int c = 0; c < 3000; c++) begin
            clear_in();
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 3) != 0)
                    put(i, AW'($urandom_range(0, 95)) + ((c % 7 == 0) ? 16'hFFC0 : 16'h0),
                        int'($urandom_range(0, 3)), 1'($urandom),
                        {$urandom, $urandom});
            end
            run_cycle("R4 R5 R6 R7 R8 random");
        end

        clear_in();
        run_cycle("R9 drain");
        finish_up();
    end
endmodule